// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs single read and write cycles to external memory or I/O devices for a small 8-bit controller core. It uses a bus on which address and data share pins. The upper address byte sits on a dedicated output port. The lower address byte and the data byte share one 8-bit port. That port comes with a separate output value, an output-enable and an input path, so a pad ring can build a tri-state pin from them. Each cycle is framed by an active-low address strobe and an active-low data strobe. A read/write line and an active-low data-memory select accompany the cycle and stay valid around both strobes.

The core hands over a request on a valid/ready interface. The request carries address, write data, direction, a memory-space flag and an extended-timing flag. Ready is high only while the controller is idle. A request is taken on a clock edge where valid and ready are both high. While a cycle is in progress ready stays low and the request inputs are not looked at, so the requester simply holds its request until it is taken. The response has no back-pressure. A one-clock done pulse marks the end of every cycle, and the read data bus carries the byte captured by the most recent read.

Each cycle is a fixed sequence of phases, and the clock counts the length of each phase. The phases are:
- address setup
- address strobe low
- address hold
- bus turnaround
- data strobe low
- data strobe recovery

The data-strobe-low phase is longer for reads than for writes. With extended timing it grows by two more clocks.

Top module: `mbus_ctrl`

## Requirements
- R1: After reset both strobes, rw_n and dm_n are 1, ad_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: req_ready is 1 only in the idle state. A request is accepted on an edge where req_valid and req_ready are both 1. Request inputs that change while a cycle runs have no effect on that cycle's pins or on its result.
- R3: After acceptance the address is driven on the shared port with ad_oe=1 and on addr_hi for T_ADDR cycles with as_n=1. as_n is then 0 for T_ASL cycles. The address stays driven with as_n=1 for T_ASH more cycles.
- R4: rw_n (0 = write, 1 = read) and dm_n (0 when the memory-space flag is 1) are valid from the first address cycle through the last recovery cycle. Both return to 1 in idle.
- R5: In a read, the shared port is released (ad_oe=0) from the turnaround phase through the recovery phase. The data strobe is never low while the address is driven.
- R6: In a write, the write data is driven with ad_oe=1 from the turnaround phase (T_FLT cycles) through the recovery phase.
- R7: ds_n is 0 for T_DSR cycles in a read and T_DSW cycles in a write. When the extended flag was 1 at acceptance, both lengths grow by EXT_CYC (2).
- R8: A read captures ad_i as it stands in the last data-strobe-low cycle, at the edge where ds_n rises. A write leaves rsp_rdata unchanged.
- R9: ds_n stays 1 for T_DSH recovery cycles. The next cycle is idle and carries rsp_done=1 for exactly one clock. A new request can be accepted in that same idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dmem | input | 1 | 1 = data-memory space |
| req_ext | input | 1 | 1 = extended timing for this cycle |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| addr_hi | output | 8 | Upper address byte |
| ad_o | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_i | input | 8 | Shared port input value |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | 1 = read, 0 = write |
| dm_n | output | 1 | Data-memory select, active low |

## Verification
The hardest cases to reach from the ports are two. The first is proving that the read byte is taken in exactly the last data-strobe-low cycle. The second is proving that a request changing mid-cycle leaves the running cycle untouched. The bench changes ad_i to a different value in every cycle, so the captured byte names the cycle it was sampled in. Between acceptances it holds req_valid high with scrambled fields. Transactions follow back to back, each new request taken in the done cycle. The bench sweeps every combination of direction, memory space and extended timing over several address and data patterns. It compares every pin in every cycle against phase boundaries it computes from the timing parameters.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_ASL  = 3'd2,
    PH_ASH  = 3'd3,
    PH_FLT  = 3'd4,
    PH_DSL  = 3'd5,
    PH_DSH  = 3'd6
  } phase_e;

  function automatic phase_e next_phase(phase_e p);
    case (p)
      PH_IDLE: next_phase = PH_ADDR;
      PH_ADDR: next_phase = PH_ASL;
      PH_ASL:  next_phase = PH_ASH;
      PH_ASH:  next_phase = PH_FLT;
      PH_FLT:  next_phase = PH_DSL;
      PH_DSL:  next_phase = PH_DSH;
      default: next_phase = PH_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/mbus_timer.sv
module mbus_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mbus_req_hold.sv
module mbus_req_hold #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          in_write,
  input  logic          in_dmem,
  input  logic          in_ext,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_wdata,
  output logic          q_write,
  output logic          q_dmem,
  output logic          q_ext
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_wdata <= '0;
      q_write <= 1'b0;
      q_dmem  <= 1'b0;
      q_ext   <= 1'b0;
    end else if (take) begin
      q_addr  <= in_addr;
      q_wdata <= in_wdata;
      q_write <= in_write;
      q_dmem  <= in_dmem;
      q_ext   <= in_ext;
    end
  end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int T_ADDR  = 1,
  parameter int T_ASL   = 1,
  parameter int T_ASH   = 1,
  parameter int T_FLT   = 1,
  parameter int T_DSR   = 3,
  parameter int T_DSW   = 2,
  parameter int T_DSH   = 1,
  parameter int EXT_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   cyc_write,
  input  logic   cyc_ext,
  output phase_e phase,
  output logic   idle,
  output logic   capture,
  output logic   finish
);
  localparam int M1   = (T_ADDR > T_ASL) ? T_ADDR : T_ASL;
  localparam int M2   = (M1 > T_ASH) ? M1 : T_ASH;
  localparam int M3   = (M2 > T_FLT) ? M2 : T_FLT;
  localparam int M4   = (M3 > T_DSH) ? M3 : T_DSH;
  localparam int MDS  = ((T_DSR > T_DSW) ? T_DSR : T_DSW) + EXT_CYC;
  localparam int MAXD = (M4 > MDS) ? M4 : MDS;
  localparam int CW   = $clog2(MAXD + 1);

  phase_e        ph_q, ph_nx;
  logic          expired, load;
  logic [CW-1:0] load_val;

  function automatic logic [CW-1:0] dur_m1(phase_e p, logic wr, logic ex);
    int d;
    case (p)
      PH_ADDR: d = T_ADDR;
      PH_ASL:  d = T_ASL;
      PH_ASH:  d = T_ASH;
      PH_FLT:  d = T_FLT;
      PH_DSL:  d = (wr ? T_DSW : T_DSR) + (ex ? EXT_CYC : 0);
      PH_DSH:  d = T_DSH;
      default: d = 1;
    endcase
    dur_m1 = CW'(d - 1);
  endfunction

  assign idle     = (ph_q == PH_IDLE);
  assign ph_nx    = next_phase(ph_q);
  assign load     = idle ? start : expired;
  assign load_val = dur_m1(ph_nx, cyc_write, cyc_ext);

  mbus_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph_q <= PH_IDLE;
    else if (load) ph_q <= ph_nx;
  end

  assign phase   = ph_q;
  assign capture = (ph_q == PH_DSL) && expired && !cyc_write;
  assign finish  = (ph_q == PH_DSH) && expired;

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !start) |=> (ph_q == PH_IDLE)); // R2
endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          capture,
  input  logic          finish,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_wdata,
  input  logic          q_write,
  input  logic          q_dmem,
  input  logic [DW-1:0] ad_i,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic          as_n,
  output logic          ds_n,
  output logic          rw_n,
  output logic          dm_n,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata
);
  logic active, addr_ph, data_ph, wr_drive;

  always_comb begin
    active   = (phase != PH_IDLE);
    addr_ph  = (phase == PH_ADDR) || (phase == PH_ASL) || (phase == PH_ASH);
    data_ph  = (phase == PH_FLT) || (phase == PH_DSL) || (phase == PH_DSH);
    wr_drive = data_ph && q_write;
    as_n     = (phase != PH_ASL);
    ds_n     = (phase != PH_DSL);
    rw_n     = active ? !q_write : 1'b1;
    dm_n     = active ? !q_dmem  : 1'b1;
    ad_oe    = addr_ph || wr_drive;
    if (addr_ph)       ad_o = q_addr[DW-1:0];
    else if (wr_drive) ad_o = q_wdata;
    else               ad_o = '0;
  end

  assign addr_hi = q_addr[AW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= finish;
      if (capture) rsp_rdata <= ad_i;
    end
  end

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R9
  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && rw_n) |-> !ad_oe); // R5
  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && !rw_n) |-> ad_oe); // R6
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int T_ADDR  = 1,
  parameter int T_ASL   = 1,
  parameter int T_ASH   = 1,
  parameter int T_FLT   = 1,
  parameter int T_DSR   = 3,
  parameter int T_DSW   = 2,
  parameter int T_DSH   = 1,
  parameter int EXT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_write,
  input  logic             req_dmem,
  input  logic             req_ext,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_i,
  output logic             as_n,
  output logic             ds_n,
  output logic             rw_n,
  output logic             dm_n
);
  phase_e        phase;
  logic          idle, take, capture, finish;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic          q_write, q_dmem, q_ext;

  assign req_ready = idle;
  assign take      = req_valid && idle;

  mbus_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .in_write (req_write),
    .in_dmem  (req_dmem),
    .in_ext   (req_ext),
    .q_addr   (q_addr),
    .q_wdata  (q_wdata),
    .q_write  (q_write),
    .q_dmem   (q_dmem),
    .q_ext    (q_ext)
  );

  mbus_seq #(
    .T_ADDR(T_ADDR), .T_ASL(T_ASL), .T_ASH(T_ASH), .T_FLT(T_FLT),
    .T_DSR(T_DSR), .T_DSW(T_DSW), .T_DSH(T_DSH), .EXT_CYC(EXT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (take),
    .cyc_write (q_write),
    .cyc_ext   (q_ext),
    .phase     (phase),
    .idle      (idle),
    .capture   (capture),
    .finish    (finish)
  );

  mbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .capture   (capture),
    .finish    (finish),
    .q_addr    (q_addr),
    .q_wdata   (q_wdata),
    .q_write   (q_write),
    .q_dmem    (q_dmem),
    .ad_i      (ad_i),
    .addr_hi   (addr_hi),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .rw_n      (rw_n),
    .dm_n      (dm_n),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (as_n && ds_n && rw_n && dm_n)); // R2
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(!as_n && !ds_n)); // R3
  AST_CTRL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && $past(!ds_n)) |-> ($stable(rw_n) && $stable(dm_n))); // R4
  AST_DS_AFTER_AS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n) |-> ($past(as_n) && !$past(req_ready))); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready); // R9
endmodule

// File: tb/mbus_ctrl_bench.sv
module mbus_ctrl_bench;
  localparam int TA = 1, TASL = 1, TASH = 1, TF = 1, TDR = 3, TDW = 2, TDH = 1, EXT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0, req_dmem = 1'b0, req_ext = 1'b0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata, addr_hi, ad_o, ad_i = '0;
  logic        ad_oe, as_n, ds_n, rw_n, dm_n;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;
  logic [7:0] last_rd = '0;

  always #4 clk = ~clk;

  mbus_ctrl #(
    .T_ADDR(TA), .T_ASL(TASL), .T_ASH(TASH), .T_FLT(TF),
    .T_DSR(TDR), .T_DSW(TDW), .T_DSH(TDH), .EXT_CYC(EXT)
  ) u_mbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_dmem(req_dmem), .req_ext(req_ext), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .addr_hi(addr_hi), .ad_o(ad_o), .ad_oe(ad_oe),
    .ad_i(ad_i), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dm_n(dm_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] drv(int seed, int k);
    return 8'(seed * 7 + k * 13 + 5);
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_cyc(input bit w, input bit d, input bit e,
                         input logic [15:0] a, input logic [7:0] wd,
                         input int seed, input bit noise);
    int b1, b2, b3, b4, b5, n;
    logic [7:0] exp_rd;
    b1 = TA; b2 = b1 + TASL; b3 = b2 + TASH; b4 = b3 + TF;
    b5 = b4 + (w ? TDW : TDR) + (e ? EXT : 0); n = b5 + TDH;
    exp_rd = last_rd;
    chk("R2 ready before accept", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_wdata = wd;
    req_write = w; req_dmem = d; req_ext = e;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (noise) begin
        req_valid = 1'b1; req_addr = ~a ^ 16'(k); req_wdata = ~wd;
        req_write = ~w; req_dmem = ~d; req_ext = ~e;
      end else req_valid = 1'b0;
      chk("R2 ready busy", {31'd0, req_ready}, 32'd0);
      chk("R3 as_n", {31'd0, as_n}, {31'd0, !(k > b1 && k <= b2)});
      chk("R7 ds_n", {31'd0, ds_n}, {31'd0, !(k > b4 && k <= b5)});
      chk("R4 rw_n dm_n", {30'd0, rw_n, dm_n}, {30'd0, !w, !d});
      if (k <= b3) begin
        chk("R3 address drive", {15'd0, ad_oe, addr_hi, ad_o}, {15'd0, 1'b1, a});
      end else if (w) begin
        chk("R6 write data drive", {23'd0, ad_oe, ad_o}, {23'd0, 1'b1, wd});
        chk("R3 addr_hi held", {24'd0, addr_hi}, {24'd0, a[15:8]});
      end else begin
        chk("R5 bus released", {31'd0, ad_oe}, 32'd0);
      end
      chk("R9 no early done", {31'd0, rsp_done}, 32'd0);
      ad_i = drv(seed, k);
      if (!w && k == b5) exp_rd = ad_i;
      if (k == n) req_valid = 1'b0;
    end
    @(negedge clk);
    chk("R9 done pulse", {31'd0, rsp_done}, 32'd1);
    chk("R9 idle ready", {31'd0, req_ready}, 32'd1);
    chk("R4 idle rw_n dm_n", {28'd0, rw_n, dm_n, as_n, ds_n}, 32'hF);
    chk("R8 read data", {24'd0, rsp_rdata}, {24'd0, exp_rd});
    last_rd = exp_rd;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {28'd0, as_n, ds_n, rw_n, dm_n}, 32'hF);
    chk("R1 reset oe ready done", {29'd0, ad_oe, req_ready, rsp_done}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {27'd0, ad_oe, req_ready, rsp_done, as_n, ds_n}, 32'h0B);
    chk("R8 reset rdata", {24'd0, rsp_rdata}, 32'd0);
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 8; c++) begin
        run_cyc(c[0], c[1], c[2], 16'h1234 * 16'(p + 1) ^ 16'(c * 16'h0F11),
                8'h5A ^ 8'(p * 37 + c), p * 8 + c, (c + p) % 2 == 1);
      end
    end
    @(negedge clk);
    chk("R9 single done", {31'd0, rsp_done}, 32'd0);
    chk("R2 stays idle without request", {30'd0, req_ready, as_n}, 32'd3);
    finish_run();
  end
endmodule